// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit for a 32-bit base integer core. Two operands and a 4-bit operation code go in, and one 32-bit result comes out in the same cycle. The unit performs wrap-around addition and subtraction, the three bitwise logic functions, the three shifts, and the signed and unsigned less-than tests.

Register-register and register-immediate instructions share the unit. For the immediate forms the surrounding datapath sign-extends the 12-bit immediate to 32 bits and presents it on the second operand. The unit never sees whether a value came from a register or an immediate. Shifts take their distance from the low five bits of the second operand only.

Operation codes (`op_sel_i`): 0x0 add, 0x8 subtract, 0x1 shift left, 0x2 signed less-than, 0x3 unsigned less-than, 0x4 XOR, 0x5 logical right shift, 0xD arithmetic right shift, 0x6 OR, 0x7 AND. The remaining six codes (0x9, 0xA, 0xB, 0xC, 0xE, 0xF) are unused.

Top module: `int_alu`

## Requirements
- R1: Code 0x0 returns opa + opb modulo 2^32, with no overflow indication.
- R2: Code 0x8 returns opa − opb modulo 2^32.
- R3: Codes 0x7, 0x6 and 0x4 return the bitwise AND, OR and XOR of the operands.
- R4: Code 0x1 shifts opa left by opb[4:0] and fills with zeros. Bits opb[31:5] have no effect.
- R5: Code 0x5 shifts opa right by opb[4:0] and fills with zeros.
- R6: Code 0xD shifts opa right by opb[4:0] and copies opa[31] into every vacated upper bit.
- R7: Code 0x2 returns 1 when opa is less than opb as two's-complement numbers, and 0 otherwise.
- R8: Code 0x3 returns 1 when opa is less than opb as unsigned numbers, and 0 otherwise.
- R9: Each of the six unused codes returns zero.
- R10: For an immediate on opb, every operation uses the 12-bit immediate sign-extended to 32 bits. With code 0x3 that extended value is compared as an unsigned number, so an immediate of 0xFFF tests against 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand: a register value or a sign-extended immediate |
| op_sel_i | input | 4 | Operation code |
| res_o | output | 32 | Result, combinational |

## Verification
Addition and subtraction are driven across the 2^32 wrap and across the signed boundary between 0x7FFFFFFF and 0x80000000. This separates true modulo arithmetic from a saturating or sign-confused adder. The shifts use distances 0, 1, an interior value and 31, with garbage in opb[31:5]. They run on operands with the top bit both set and clear, which separates zero fill from sign fill and exposes any use of the high distance bits. The two comparisons get operand pairs that are equal, differ only in sign, and sit at the extreme values. Only a correct split between signed and unsigned ordering gets all of them right. Every unused code, sign-extended immediates and a seeded pseudo-random sweep over all codes complete the set, with each expected result computed by a separate behavioural model.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SLL  = 4'h1,
      OP_SLT  = 4'h2,
      OP_SLTU = 4'h3,
      OP_XOR  = 4'h4,
      OP_SRL  = 4'h5,
      OP_OR   = 4'h6,
      OP_AND  = 4'h7,
      OP_SUB  = 4'h8,
      OP_SRA  = 4'hD
   } alu_op_e;

   function automatic logic op_is_valid(input logic [3:0] code);
      case (code)
         OP_ADD, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
         OP_SRL, OP_OR, OP_AND, OP_SUB, OP_SRA: return 1'b1;
         default:                               return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/int_alu_addsub.sv
`timescale 1ns/1ps
module int_alu_addsub #(
   parameter int XLEN           = 32,
   parameter bit CMP_FROM_ADDER = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            sub_i,
   output logic [XLEN-1:0] sum_o,
   output logic            lt_o,
   output logic            ltu_o
);

   localparam int MSB = XLEN - 1;

   logic [XLEN-1:0] b_eff;
   logic [XLEN:0]   wide;

   assign b_eff = b_i ^ {XLEN{sub_i}};
   assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
   assign sum_o = wide[MSB:0];

   generate
      if (CMP_FROM_ADDER) begin : g_shared_cmp
         // borrow out of a - b gives unsigned order; sign of the difference,
         // corrected when operand signs differ, gives signed order
         assign ltu_o = ~wide[XLEN];
         assign lt_o  = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : wide[MSB];
      end else begin : g_split_cmp
         assign ltu_o = (a_i < b_i);
         assign lt_o  = ($signed(a_i) < $signed(b_i));
      end
   endgenerate

   always_comb begin
      if (sub_i && (a_i == b_i)) begin
         a_r7_r8_equal_not_less : assert (!lt_o && !ltu_o)
            else $error("equal operands reported as less");
      end
      if (sub_i && (a_i[MSB] != b_i[MSB])) begin
         a_r7_r8_sign_split : assert (lt_o == !ltu_o)
            else $error("signed/unsigned order inconsistent for mixed signs");
      end
      if (sub_i && (a_i[MSB] == b_i[MSB])) begin
         a_r7_r8_sign_same : assert (lt_o == ltu_o)
            else $error("signed/unsigned order differ for same signs");
      end
   end

endmodule

// File: rtl/int_alu_logic.sv
`timescale 1ns/1ps
module int_alu_logic #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] and_o,
   output logic [XLEN-1:0] or_o,
   output logic [XLEN-1:0] xor_o
);

   generate
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
         assign and_o[i] = a_i[i] & b_i[i];
         assign or_o[i]  = a_i[i] | b_i[i];
         assign xor_o[i] = a_i[i] ^ b_i[i];
      end
   endgenerate

   always_comb begin
      a_r3_xor_consistent : assert (xor_o == (or_o & ~and_o))
         else $error("logic outputs mutually inconsistent");
   end

endmodule

// File: rtl/int_alu_shifter.sv
`timescale 1ns/1ps
module int_alu_shifter #(
   parameter int XLEN        = 32,
   parameter bit SHARED_PATH = 1'b1,
   localparam int SHW        = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [SHW-1:0]  shamt_i,
   input  logic            left_i,
   input  logic            arith_i,
   output logic [XLEN-1:0] y_o
);

   localparam int MSB = XLEN - 1;

   generate
      if (SHARED_PATH) begin : g_shared
         // one right shifter; left shifts run through it bit-reversed
         logic [XLEN-1:0] a_rev;
         logic [XLEN-1:0] r_rev;
         logic [XLEN-1:0] src;
         logic [XLEN-1:0] stg [SHW+1];
         logic            fill;

         for (genvar i = 0; i < XLEN; i++) begin : g_rev
            assign a_rev[i] = a_i[MSB-i];
            assign r_rev[i] = stg[SHW][MSB-i];
         end

         assign src    = left_i ? a_rev : a_i;
         assign fill   = arith_i & ~left_i & a_i[MSB];
         assign stg[0] = src;

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            assign stg[s+1] = shamt_i[s]
                            ? {{DIST{fill}}, stg[s][MSB:DIST]}
                            : stg[s];
         end

         assign y_o = left_i ? r_rev : stg[SHW];
      end else begin : g_split
         logic [XLEN-1:0] sl;
         logic [XLEN-1:0] sr;
         assign sl  = a_i << shamt_i;
         assign sr  = arith_i ? $unsigned($signed(a_i) >>> shamt_i)
                              : (a_i >> shamt_i);
         assign y_o = left_i ? sl : sr;
      end
   endgenerate

   always_comb begin
      if (shamt_i == '0) begin
         a_r4_r5_zero_distance : assert (y_o == a_i)
            else $error("zero-distance shift altered operand");
      end
      if (!left_i && arith_i && a_i[MSB]) begin
         a_r6_sign_fill : assert (y_o[MSB])
            else $error("arithmetic shift lost sign bit");
      end
      if (!left_i && !arith_i && (shamt_i != '0)) begin
         a_r5_zero_fill : assert (!y_o[MSB])
            else $error("logical right shift filled with one");
      end
      if (left_i && (shamt_i != '0)) begin
         a_r4_low_zero : assert (!y_o[0])
            else $error("left shift filled low bit with one");
      end
   end

endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu
   import int_alu_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter bit CMP_FROM_ADDER = 1'b1,
   parameter bit SHARED_SHIFT   = 1'b1
) (
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   input  logic [3:0]      op_sel_i,
   output logic [XLEN-1:0] res_o
);

   localparam int SHW = $clog2(XLEN);

   generate
      if ((XLEN < 8) || ((1 << SHW) != XLEN)) begin : g_bad_xlen
         $error("XLEN must be a power of two of at least 8");
      end
   endgenerate

   logic [XLEN-1:0] sum;
   logic            lt;
   logic            ltu;
   logic [XLEN-1:0] v_and;
   logic [XLEN-1:0] v_or;
   logic [XLEN-1:0] v_xor;
   logic [XLEN-1:0] v_shift;
   logic            do_sub;
   logic            sh_left;
   logic            sh_arith;

   assign do_sub   = (op_sel_i != OP_ADD);
   assign sh_left  = (op_sel_i == OP_SLL);
   assign sh_arith = (op_sel_i == OP_SRA);

   int_alu_addsub #(
      .XLEN           (XLEN),
      .CMP_FROM_ADDER (CMP_FROM_ADDER)
   ) u_addsub (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sub_i (do_sub),
      .sum_o (sum),
      .lt_o  (lt),
      .ltu_o (ltu)
   );

   int_alu_logic #(
      .XLEN (XLEN)
   ) u_logic (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .and_o (v_and),
      .or_o  (v_or),
      .xor_o (v_xor)
   );

   int_alu_shifter #(
      .XLEN        (XLEN),
      .SHARED_PATH (SHARED_SHIFT)
   ) u_shifter (
      .a_i     (opa_i),
      .shamt_i (opb_i[SHW-1:0]),
      .left_i  (sh_left),
      .arith_i (sh_arith),
      .y_o     (v_shift)
   );

   always_comb begin
      case (op_sel_i)
         OP_ADD,
         OP_SUB:  res_o = sum;
         OP_AND:  res_o = v_and;
         OP_OR:   res_o = v_or;
         OP_XOR:  res_o = v_xor;
         OP_SLL,
         OP_SRL,
         OP_SRA:  res_o = v_shift;
         OP_SLT:  res_o = {{(XLEN-1){1'b0}}, lt};
         OP_SLTU: res_o = {{(XLEN-1){1'b0}}, ltu};
         default: res_o = '0;
      endcase
   end

   always_comb begin
      if (op_sel_i == OP_ADD) begin
         a_r1_add_inverse : assert ((res_o - opb_i) == opa_i)
            else $error("sum does not invert");
      end
      if (op_sel_i == OP_SUB) begin
         a_r2_sub_inverse : assert ((res_o + opb_i) == opa_i)
            else $error("difference does not invert");
      end
      if ((op_sel_i == OP_SLT) || (op_sel_i == OP_SLTU)) begin
         a_r7_r8_boolean : assert (res_o[XLEN-1:1] == '0)
            else $error("compare result not 0 or 1");
      end
      if (!op_is_valid(op_sel_i)) begin
         a_r9_unused_zero : assert (res_o == '0)
            else $error("unused code gave nonzero result");
      end
   end

endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [3:0]  op  = '0;
   logic [31:0] res;

   int unsigned n_vec  = 0;
   int unsigned n_fail = 0;
   int unsigned cycles = 0;
   bit          done   = 1'b0;
   logic [31:0] rng    = 32'h1234_5678;

   always #2.5 clk = ~clk;

   int_alu u_int_alu (
      .opa_i    (opa),
      .opb_i    (opb),
      .op_sel_i (op),
      .res_o    (res)
   );

   function automatic logic [31:0] model(input logic [3:0] c,
                                         input logic [31:0] a,
                                         input logic [31:0] b);
      logic [4:0] d;
      d = b[4:0];
      case (c)
         4'h0: return a + b;
         4'h8: return a - b;
         4'h7: return a & b;
         4'h6: return a | b;
         4'h4: return a ^ b;
         4'h1: return a << d;
         4'h5: return a >> d;
         4'hD: return $unsigned($signed(a) >>> d);
         4'h2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'h3: return (a < b) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] sext12(input logic [11:0] imm);
      return {{20{imm[11]}}, imm};
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic apply(input string tag, input logic [3:0] c,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp);
      @(negedge clk);
      op  = c;
      opa = a;
      opb = b;
      #1;
      n_vec++;
      if (res !== exp) begin
         n_fail++;
         $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h",
                  tag, c, a, b, res, exp);
      end
   endtask

   task automatic run(input string tag, input logic [3:0] c,
                      input logic [31:0] a, input logic [31:0] b);
      apply(tag, c, a, b, model(c, a, b));
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      n_vec++;
      if (res !== 32'd0) begin
         n_fail++;
         $display("FAIL R1 reset-time result actual=%h expected=%h", res, 32'd0);
      end
      rst = 1'b0;
   endtask

   task automatic t_add();
      apply("R1", 4'h0, 32'hFFFF_FFFF, 32'h1, 32'h0);
      apply("R1", 4'h0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000);
      apply("R1", 4'h0, 32'h8000_0000, 32'h8000_0000, 32'h0);
      run("R1", 4'h0, 32'h1357_9BDF, 32'h0246_8ACE);
   endtask

   task automatic t_sub();
      apply("R2", 4'h8, 32'h0, 32'h1, 32'hFFFF_FFFF);
      apply("R2", 4'h8, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF);
      apply("R2", 4'h8, 32'h1234_5678, 32'h1234_5678, 32'h0);
      run("R2", 4'h8, 32'h0000_0005, 32'h0000_0009);
   endtask

   task automatic t_logic();
      apply("R3", 4'h7, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000);
      apply("R3", 4'h6, 32'hF0F0_F0F0, 32'h0F00_0F00, 32'hFFF0_FFF0);
      apply("R3", 4'h4, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h5555_5555);
   endtask

   task automatic t_sll();
      apply("R4", 4'h1, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000);
      apply("R4", 4'h1, 32'h0000_00FF, 32'hFFFF_FFE3, 32'h0000_07F8);
      apply("R4", 4'h1, 32'hDEAD_BEEF, 32'h0000_0020, 32'hDEAD_BEEF);
   endtask

   task automatic t_srl();
      apply("R5", 4'h5, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001);
      apply("R5", 4'h5, 32'hF000_0000, 32'h0000_0004, 32'h0F00_0000);
      apply("R5", 4'h5, 32'hCAFE_F00D, 32'h0000_0000, 32'hCAFE_F00D);
   endtask

   task automatic t_sra();
      apply("R6", 4'hD, 32'h8000_0000, 32'h0000_001F, 32'hFFFF_FFFF);
      apply("R6", 4'hD, 32'hF000_0000, 32'h0000_0004, 32'hFF00_0000);
      apply("R6", 4'hD, 32'h7000_0000, 32'hFFFF_FFE4, 32'h0700_0000);
      apply("R6", 4'hD, 32'h8000_0001, 32'h0000_0001, 32'hC000_0000);
   endtask

   task automatic t_slt();
      apply("R7", 4'h2, 32'hFFFF_FFFF, 32'h0, 32'd1);
      apply("R7", 4'h2, 32'h0, 32'hFFFF_FFFF, 32'd0);
      apply("R7", 4'h2, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1);
      apply("R7", 4'h2, 32'h0000_0042, 32'h0000_0042, 32'd0);
   endtask

   task automatic t_sltu();
      apply("R8", 4'h3, 32'hFFFF_FFFF, 32'h0, 32'd0);
      apply("R8", 4'h3, 32'h0, 32'hFFFF_FFFF, 32'd1);
      apply("R8", 4'h3, 32'h7FFF_FFFF, 32'h8000_0000, 32'd1);
      apply("R8", 4'h3, 32'h8000_0000, 32'h8000_0000, 32'd0);
   endtask

   task automatic t_imm();
      apply("R10", 4'h3, 32'h0000_0005, sext12(12'hFFF), 32'd1);
      apply("R10", 4'h3, 32'hFFFF_FFFF, sext12(12'hFFF), 32'd0);
      apply("R10", 4'h0, 32'h0000_1000, sext12(12'h800), 32'h0000_0800);
      apply("R10", 4'h7, 32'h1234_5678, sext12(12'hFF0), 32'h1234_5670);
      apply("R10", 4'h4, 32'h0000_0000, sext12(12'hFFF), 32'hFFFF_FFFF);
      apply("R10", 4'h2, 32'hFFFF_FFFE, sext12(12'hFFF), 32'd1);
   endtask

   task automatic t_unused();
      logic [3:0] codes [6];
      codes = '{4'h9, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF};
      for (int k = 0; k < 6; k++) begin
         rng = next_rand(rng);
         apply("R9", codes[k], rng, ~rng, 32'd0);
      end
   endtask

   task automatic t_random();
      logic [3:0] ops [10];
      ops = '{4'h0, 4'h8, 4'h7, 4'h6, 4'h4, 4'h1, 4'h5, 4'hD, 4'h2, 4'h3};
      for (int k = 0; k < 400; k++) begin
         logic [31:0] a;
         logic [31:0] b;
         rng = next_rand(rng);
         a   = rng;
         rng = next_rand(rng);
         b   = rng;
         case (ops[k % 10])
            4'h0: run("R1", 4'h0, a, b);
            4'h8: run("R2", 4'h8, a, b);
            4'h7, 4'h6, 4'h4: run("R3", ops[k % 10], a, b);
            4'h1: run("R4", 4'h1, a, b);
            4'h5: run("R5", 4'h5, a, b);
            4'hD: run("R6", 4'hD, a, b);
            4'h2: run("R7", 4'h2, a, b);
            default: run("R8", 4'h3, a, b);
         endcase
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_sll();
      t_srl();
      t_sra();
      t_slt();
      t_sltu();
      t_imm();
      t_unused();
      t_random();
      finish_run();
   end

endmodule